// File: doc/BRIEF.md
# Multi-Channel Down-Counter Timer with Latched Readback

This block holds several independent down-counting timer channels behind a small memory-mapped register port. Each channel counts down from a programmed start value. In single-run mode it stops once it expires. In repeating mode it reloads itself on every expiry. Each expiry sets a sticky status flag, and each channel drives its own interrupt line, which a per-channel mask can hold low.

The count register that software reads is not live. It returns a frozen copy of the counter. Software refreshes that copy by setting a request bit in the channel's control word. The hardware takes the copy on the next clock and then sets a valid flag. Until the next request, reads keep returning the old copy. Status is cleared through a write-only acknowledge register.

The register port is a plain strobe interface. A write takes effect at the clock edge where `bus_we` is high, and a read returns combinational data for the current `bus_addr`. Neither direction has back-pressure, so every access completes in one cycle. Channel `c` occupies 0x14 bytes starting at `c*0x14`. Its word offsets are: start value 0x00, latched count 0x04, control 0x08, acknowledge 0x0C, status 0x10.

Top module: `tmr_bank`

## Requirements
- R1: After reset every readable register of every channel returns zero and all interrupt outputs are low.
- R2: The control word reads back its stored fields: enable bit 0, mode bits [2:1], mask bit 3, request bit 5, valid bit 6. All other bits read zero. Mode value 1 selects repeating and any other value selects single-run.
- R3: A write that sets enable on a disabled channel loads the counter from the start value. With start value L, status bit 0 rises after L+1 clock edges counted from that write. In single-run mode the count then holds at zero and the channel never expires again.
- R4: In repeating mode the channel reloads the start value on each expiry, so it expires every L+1 clocks.
- R5: Status bit 0 stays set until a 1 is written to bit 0 of the channel's acknowledge register. Writing 0 there has no effect, and the acknowledge register always reads zero.
- R6: The interrupt output equals status bit 0 while mask bit 3 is clear. While the mask is set the output is low, but status still records expiry.
- R7: On an enabled channel, one clock after a request is written the latched count register holds the counter's value from that cycle, the valid bit is 1, and the request bit is 0.
- R8: Without a new request the latched count register keeps its value while the counter runs.
- R9: On a disabled channel a request does not update the latched count and the valid bit stays 0. Any control write that sets the request bit or clears enable also clears the valid bit.
- R10: A start value written while the channel is disabled reads back at once and sets the expiry time of the next enable.
- R11: Channels are independent. Addresses outside the channel windows, and misaligned addresses, read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | NUM_CH | Per-channel interrupt lines |

## Verification
A wrong counter or reload shows at the ports as a status bit that rises one or more edges away from L+1 (or 2L+2 in repeating mode). The bench checks the edge just before and the edge of expiry, so an off-by-one error shows within a single period. A wrong copy or valid bit shows one clock after a request, as a wrong latched value or control readback. A copy that drifts without a request shows at the next read a few cycles later, because the value no longer matches the one computed from the request cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BUS_W = 32;
  localparam int WIN   = 20;

  localparam int CB_EN   = 0;
  localparam int CB_MODE = 1;
  localparam int CB_MASK = 3;
  localparam int CB_REQ  = 5;
  localparam int CB_LOCK = 6;

  localparam logic [1:0] MODE_REPEAT = 2'd1;

  typedef enum logic [2:0] {
    REG_START = 3'd0,
    REG_LATCH = 3'd1,
    REG_CTRL  = 3'd2,
    REG_ACK   = 3'd3,
    REG_STAT  = 3'd4,
    REG_NONE  = 3'd7
  } reg_kind_e;
endpackage

// File: rtl/tmr_addr_dec.sv
module tmr_addr_dec
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_CH-1:0] ch_sel,
  output reg_kind_e         kind
);
  logic [31:0] a_ext;
  logic [31:0] off;

  assign a_ext = 32'(addr);

  always_comb begin
    ch_sel = '0;
    off    = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (a_ext >= 32'(c * WIN) && a_ext < 32'((c + 1) * WIN)) begin
        ch_sel[c] = 1'b1;
        off       = a_ext - 32'(c * WIN);
      end
    end
  end

  always_comb begin
    kind = REG_NONE;
    if (|ch_sel) begin
      case (off)
        32'h00:  kind = REG_START;
        32'h04:  kind = REG_LATCH;
        32'h08:  kind = REG_CTRL;
        32'h0C:  kind = REG_ACK;
        32'h10:  kind = REG_STAT;
        default: kind = REG_NONE;
      endcase
    end
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_start,
  input  logic             wr_ctrl,
  input  logic             wr_ack,
  input  logic [BUS_W-1:0] wdata,
  output logic [CNT_W-1:0] start_o,
  output logic [CNT_W-1:0] latch_o,
  output logic [BUS_W-1:0] ctrl_o,
  output logic             stat_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] start_q, cnt_q, latch_q;
  logic             en_q, mask_q, req_q, lock_q, stat_q, done_q;
  logic [1:0]       mode_q;
  logic             kick, running, expire, capture;

  assign kick    = wr_ctrl && wdata[CB_EN] && !en_q;
  assign running = en_q && !done_q;
  assign expire  = running && (cnt_q == '0);
  assign capture = req_q && en_q && !wr_ctrl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      en_q    <= 1'b0;
      mode_q  <= '0;
      mask_q  <= 1'b0;
      req_q   <= 1'b0;
      lock_q  <= 1'b0;
      latch_q <= '0;
    end else begin
      if (wr_start) start_q <= wdata[CNT_W-1:0];
      if (wr_ctrl) begin
        en_q   <= wdata[CB_EN];
        mode_q <= wdata[CB_MODE+1:CB_MODE];
        mask_q <= wdata[CB_MASK];
        req_q  <= wdata[CB_REQ];
        if (wdata[CB_REQ] || !wdata[CB_EN]) lock_q <= 1'b0;
      end else if (capture) begin
        latch_q <= cnt_q;
        lock_q  <= 1'b1;
        req_q   <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (kick) begin
      cnt_q  <= start_q;
      done_q <= 1'b0;
    end else if (expire) begin
      if (mode_q == MODE_REPEAT) cnt_q <= start_q;
      else                       done_q <= 1'b1;
    end else if (running) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   stat_q <= 1'b0;
    else if (expire)              stat_q <= 1'b1;
    else if (wr_ack && wdata[0])  stat_q <= 1'b0;
  end

  always_comb begin
    ctrl_o                          = '0;
    ctrl_o[CB_EN]                   = en_q;
    ctrl_o[CB_MODE+1:CB_MODE]       = mode_q;
    ctrl_o[CB_MASK]                 = mask_q;
    ctrl_o[CB_REQ]                  = req_q;
    ctrl_o[CB_LOCK]                 = lock_q;
  end

  assign start_o = start_q;
  assign latch_o = latch_q;
  assign stat_o  = stat_q;
  assign irq_o   = stat_q && !mask_q;

  // R5: status is sticky until acknowledged
  a_r5_stat_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q && !wr_ack |=> stat_q);

  // R7: a pending request on a running channel completes in one clock
  a_r7_lock_next: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> lock_q && !req_q);

  // R8: latched copy only moves on a capture
  a_r8_latch_stale: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(latch_q));

  // R3: a finished single-run channel holds its count
  a_r3_oneshot_halt: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !wr_ctrl |=> $stable(cnt_q));

  // R9: disabled channel never shows a valid copy
  a_r9_no_lock_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q && !wr_ctrl |=> !lock_q);

  // R4: repeating expiry reloads the start value
  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    expire && mode_q == MODE_REPEAT && !wr_ctrl |=> cnt_q == $past(start_q));
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  logic [NUM_CH-1:0] ch_sel;
  reg_kind_e         kind;
  logic [CNT_W-1:0]  start_v [NUM_CH];
  logic [CNT_W-1:0]  latch_v [NUM_CH];
  logic [BUS_W-1:0]  ctrl_v  [NUM_CH];
  logic [NUM_CH-1:0] stat_v;

  tmr_addr_dec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .addr   (bus_addr),
    .ch_sel (ch_sel),
    .kind   (kind)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_start (bus_we && ch_sel[c] && kind == REG_START),
      .wr_ctrl  (bus_we && ch_sel[c] && kind == REG_CTRL),
      .wr_ack   (bus_we && ch_sel[c] && kind == REG_ACK),
      .wdata    (bus_wdata),
      .start_o  (start_v[c]),
      .latch_o  (latch_v[c]),
      .ctrl_o   (ctrl_v[c]),
      .stat_o   (stat_v[c]),
      .irq_o    (irq[c])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_sel[c]) begin
        case (kind)
          REG_START: bus_rdata = BUS_W'(start_v[c]);
          REG_LATCH: bus_rdata = BUS_W'(latch_v[c]);
          REG_CTRL:  bus_rdata = ctrl_v[c];
          REG_STAT:  bus_rdata = BUS_W'(stat_v[c]);
          default:   bus_rdata = '0;
        endcase
      end
    end
  end

  // R1: no interrupt line is active straight out of reset
  a_r1_irq_reset: assert property (@(posedge clk)
    !rst_n |=> irq == '0);

  // R11: decoder selects at most one channel
  a_r11_one_window: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_sel));
endmodule

// File: tb/tmr_bank_tb.sv
module tmr_bank_tb;
  localparam int NC = 3;
  localparam int WIN = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NC-1:0] irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  tmr_bank #(.NUM_CH(NC), .CNT_W(32), .ADDR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [7:0] ra(input int ch, input int off);
    return 8'(ch * WIN + off);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  logic [31:0] v;

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    // R1: reset state
    for (int c = 0; c < NC; c++) begin
      for (int o = 0; o <= 16; o += 4) begin
        rd(ra(c, o), v); chk("R1 reset reg", v, 0);
      end
    end
    chk("R1 irq reset", 32'(irq), 0);
    @(negedge clk); rst_n = 1'b1;
    tick(1);

    // R2: control readback
    wr(ra(1, 8), 32'h1E); rd(ra(1, 8), v); chk("R2 ctrl fields", v, 32'h0E);
    wr(ra(1, 8), 32'h04); rd(ra(1, 8), v); chk("R2 ctrl mode2", v, 32'h04);
    wr(ra(1, 8), 32'h0);  rd(ra(1, 8), v); chk("R2 ctrl clear", v, 0);

    // R3 single-run sweep on channel 0
    for (int L = 0; L <= 5; L++) begin
      wr(ra(0, 8), 0);
      wr(ra(0, 12), 1);
      wr(ra(0, 0), L);
      rd(ra(0, 0), v); chk("R10 start readback", v, L);
      wr(ra(0, 8), 32'h01);
      if (L > 0) tick(L);
      rd(ra(0, 16), v); chk("R3 no early expiry", v, 0);
      tick(1);
      rd(ra(0, 16), v); chk("R3 expiry at L+1", v, 1);
      chk("R6 irq follows status", 32'(irq[0]), 1);
      wr(ra(0, 12), 0);
      rd(ra(0, 16), v); chk("R5 ack zero ignored", v, 1);
      rd(ra(0, 12), v); chk("R5 ack reads zero", v, 0);
      wr(ra(0, 12), 1);
      rd(ra(0, 16), v); chk("R5 ack clears", v, 0);
      tick(L + 3);
      rd(ra(0, 16), v); chk("R3 no refire", v, 0);
      wr(ra(0, 8), 32'h21); tick(1);
      rd(ra(0, 4), v); chk("R3 count held at zero", v, 0);
      rd(ra(0, 8), v); chk("R7 valid set req cleared", v, 32'h41);
    end

    // R4 repeating sweep on channel 1, channel 0 stays quiet (R11)
    wr(ra(0, 8), 0);
    for (int L = 1; L <= 4; L++) begin
      wr(ra(1, 8), 0);
      wr(ra(1, 12), 1);
      wr(ra(1, 0), L);
      wr(ra(1, 8), 32'h03);
      tick(L);
      rd(ra(1, 16), v); chk("R4 first period early", v, 0);
      tick(1);
      rd(ra(1, 16), v); chk("R4 first expiry", v, 1);
      wr(ra(1, 12), 1);
      rd(ra(1, 16), v); chk("R4 ack", v, 0);
      tick(L - 1);
      rd(ra(1, 16), v); chk("R4 second period early", v, 0);
      tick(1);
      rd(ra(1, 16), v); chk("R4 second expiry", v, 1);
      rd(ra(0, 16), v); chk("R11 idle channel quiet", v, 0);
    end
    wr(ra(1, 8), 0);
    wr(ra(1, 12), 1);

    // R6 mask
    wr(ra(0, 12), 1);
    wr(ra(0, 0), 2);
    wr(ra(0, 8), 32'h09);
    tick(3);
    rd(ra(0, 16), v); chk("R6 masked status set", v, 1);
    chk("R6 masked irq low", 32'(irq[0]), 0);
    wr(ra(0, 8), 32'h01);
    chk("R6 unmask raises irq", 32'(irq[0]), 1);
    wr(ra(0, 12), 1);
    chk("R6 irq drops on ack", 32'(irq[0]), 0);
    wr(ra(0, 8), 0);

    // R7/R8 snapshots on channel 2
    wr(ra(2, 0), 1000);
    wr(ra(2, 8), 32'h01);
    for (int d = 0; d < 6; d++) begin
      int base_d;
      base_d = d * 3;
      tick(base_d);
      wr(ra(2, 8), 32'h21);
      // counter edges since enable: d*3 + 1 + (all previous loop cycles)
      tick(1);
      rd(ra(2, 8), v); chk("R7 valid after request", v, 32'h41);
    end
    // measured snapshot value check from a fresh enable
    wr(ra(2, 8), 0);
    wr(ra(2, 0), 500);
    wr(ra(2, 8), 32'h01);
    for (int d = 0; d < 5; d++) begin
      wr(ra(2, 8), 0);
      wr(ra(2, 8), 32'h01);
      tick(d);
      wr(ra(2, 8), 32'h21);
      tick(1);
      rd(ra(2, 4), v); chk("R7 latched value", v, 500 - (d + 1));
      tick(7);
      rd(ra(2, 4), v); chk("R8 stale copy", v, 500 - (d + 1));
    end

    // R9 disabled channel ignores request
    wr(ra(2, 8), 0);
    rd(ra(2, 8), v); chk("R9 disable clears valid", v, 0);
    wr(ra(2, 8), 32'h20);
    tick(2);
    rd(ra(2, 4), v); chk("R9 no update disabled", v, 495);
    rd(ra(2, 8), v); chk("R9 valid stays low", v, 32'h20);

    // R10 new start value used at next enable
    wr(ra(2, 8), 0);
    wr(ra(2, 12), 1);
    wr(ra(2, 0), 3);
    wr(ra(2, 8), 32'h01);
    tick(3);
    rd(ra(2, 16), v); chk("R10 not yet", v, 0);
    tick(1);
    rd(ra(2, 16), v); chk("R10 expiry with new value", v, 1);

    // R11 unmapped
    rd(8'h3C, v); chk("R11 beyond windows", v, 0);
    rd(8'hFC, v); chk("R11 top address", v, 0);
    rd(8'h2A, v); chk("R11 misaligned", v, 0);
    rd(ra(0, 16), v); chk("R11 other channel untouched", v, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule